// File: doc/BRIEF.md
# 1-Wire ROM Search Single-Step Unit

This unit carries out one bit position of a 1-Wire ROM search. After a start strobe it asks an external bit slot engine for two read slots. The first returns the bit value of the responding devices' identifiers at the current position, and the second returns its complement. From the pair it picks the branch to follow and asks the engine for one write slot that carries the chosen direction.

A pair of ones means no device answered. In that case the unit issues no write slot and reports an error status, so the caller knows the search must start over.

The caller supplies a preferred direction with the start strobe. This bit is used only when the devices disagree. The caller receives a three-bit result together with a one-cycle done pulse. The outer loop handles the rest: walking the 64 identifier positions, remembering the last discrepancy, and checking the CRC.

Top module: `owsearch_step`

## Requirements
- R1: After reset, `done_o` and `busy_o` are 0, `slot_req_o` is 0, and `status_o` is 3'b000.
- R2: An accepted start first issues exactly two read slots (`slot_wr_o`=0). The bit returned by the first is the ID bit and the bit returned by the second is the complement bit. No write slot is requested before both reads complete.
- R3: When both read bits are 1, `status_o` becomes 3'b011 and no write slot is issued.
- R4: When both read bits are 0, the direction equals the preferred-direction bit latched at start. The status is then 3'b100 for a preference of 1 and 3'b000 for a preference of 0.
- R5: When exactly one read bit is 1, the direction equals the ID bit. The status is 3'b101 when the ID bit is 1 and 3'b010 when the complement bit is 1.
- R6: Outside the error case, exactly one write slot (`slot_wr_o`=1) follows the reads, and `slot_wbit_o` equals the direction. The status field layout is: bit 0 = ID bit, bit 1 = complement bit, bit 2 = direction taken.
- R7: `done_o` is a single-cycle pulse. `status_o` changes only in the cycle `done_o` is high, and it then holds its value until the next operation completes.
- R8: A start strobe that arrives while `busy_o` is high is ignored. It does not relatch the preference, add slots, or produce an extra done pulse.
- R9: Once raised, `slot_req_o` stays high until `slot_ack_i`, and `slot_wr_o` and `slot_wbit_o` do not change while the request waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| pref_dir_i | input | 1 | Preferred direction used when the devices disagree, sampled with start |
| slot_ack_i | input | 1 | Slot engine: one-cycle completion of the requested slot |
| slot_rbit_i | input | 1 | Slot engine: sampled bus level, valid with `slot_ack_i` on read slots |
| slot_req_o | output | 1 | Slot request, held until acknowledged |
| slot_wr_o | output | 1 | Slot kind: 0 = read slot, 1 = write slot |
| slot_wbit_o | output | 1 | Bit to drive in a write slot |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | {direction, complement bit, ID bit} |

## Verification
The checker watches every cycle for several properties. It confirms that the request handshake holds steady, that no write slot is requested before two reads have been acknowledged, and that a completed write slot is followed by a done pulse whose direction bit matches the written bit. It also confirms that the error status never carries a direction and that the status moves only with done.

Other behaviour is visible only through the bench's scenarios: the full mapping from read pairs and preference to status, the absence of a write slot on the error path, and the ignoring of a start strobe mid-operation. The bench shows these by counting and ordering the slots its engine model serves, under several acknowledge latencies.

// File: rtl/owsearch_pkg.sv
package owsearch_pkg;

    localparam int unsigned STAT_W   = 3;
    localparam int unsigned STAT_ID  = 0;
    localparam int unsigned STAT_CMP = 1;
    localparam int unsigned STAT_DIR = 2;

    typedef logic [STAT_W-1:0] step_stat_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD_ID,
        ST_RD_CMP,
        ST_WR
    } step_state_e;

    typedef struct packed {
        step_state_e state;
        logic        id;
        logic        pref;
        logic        dir;
        logic        req;
        logic        wr;
        step_stat_t  pend;
        step_stat_t  status;
        logic        done;
    } step_regs_t;

endpackage

// File: rtl/owsearch_decide.sv
module owsearch_decide
    import owsearch_pkg::*;
(
    input  logic       id_i,
    input  logic       cmp_i,
    input  logic       pref_i,
    output logic       restart_o,
    output logic       dir_o,
    output step_stat_t status_o
);

    always_comb begin
        restart_o = id_i & cmp_i;
        if (id_i ^ cmp_i) begin
            // devices agree: follow the only bit present
            dir_o = id_i;
        end else if (restart_o) begin
            dir_o = 1'b0;
        end else begin
            // discrepancy: caller chooses
            dir_o = pref_i;
        end
        status_o           = '0;
        status_o[STAT_ID]  = id_i;
        status_o[STAT_CMP] = cmp_i;
        status_o[STAT_DIR] = dir_o;
    end

endmodule

// File: rtl/owsearch_seq.sv
module owsearch_seq
    import owsearch_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       start_i,
    input  logic       pref_i,
    input  logic       slot_ack_i,
    input  logic       slot_rbit_i,
    output logic       dec_id_o,
    output logic       dec_cmp_o,
    output logic       dec_pref_o,
    input  logic       dec_restart_i,
    input  logic       dec_dir_i,
    input  step_stat_t dec_status_i,
    output logic       slot_req_o,
    output logic       slot_wr_o,
    output logic       slot_wbit_o,
    output logic       busy_o,
    output logic       done_o,
    output step_stat_t status_o
);

    step_regs_t r_d, r_q;

    assign dec_id_o   = r_q.id;
    assign dec_cmp_o  = slot_rbit_i;
    assign dec_pref_o = r_q.pref;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.state = ST_RD_ID;
                    r_d.pref  = pref_i;
                    r_d.req   = 1'b1;
                    r_d.wr    = 1'b0;
                    r_d.dir   = 1'b0;
                end
            end
            ST_RD_ID: begin
                if (slot_ack_i) begin
                    r_d.id    = slot_rbit_i;
                    r_d.state = ST_RD_CMP;
                end
            end
            ST_RD_CMP: begin
                if (slot_ack_i) begin
                    if (dec_restart_i) begin
                        r_d.req    = 1'b0;
                        r_d.status = dec_status_i;
                        r_d.done   = 1'b1;
                        r_d.state  = ST_IDLE;
                    end else begin
                        r_d.pend  = dec_status_i;
                        r_d.dir   = dec_dir_i;
                        r_d.wr    = 1'b1;
                        r_d.state = ST_WR;
                    end
                end
            end
            ST_WR: begin
                if (slot_ack_i) begin
                    r_d.req    = 1'b0;
                    r_d.wr     = 1'b0;
                    r_d.status = r_q.pend;
                    r_d.done   = 1'b1;
                    r_d.state  = ST_IDLE;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q <= '{state: ST_IDLE, id: 1'b0, pref: 1'b0, dir: 1'b0,
                     req: 1'b0, wr: 1'b0, pend: '0, status: '0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign slot_req_o  = r_q.req;
    assign slot_wr_o   = r_q.wr;
    assign slot_wbit_o = r_q.dir;
    assign busy_o      = (r_q.state != ST_IDLE);
    assign done_o      = r_q.done;
    assign status_o    = r_q.status;

endmodule

// File: rtl/owsearch_step.sv
module owsearch_step
    import owsearch_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              pref_dir_i,
    input  logic              slot_ack_i,
    input  logic              slot_rbit_i,
    output logic              slot_req_o,
    output logic              slot_wr_o,
    output logic              slot_wbit_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [STAT_W-1:0] status_o
);

    logic       dec_id, dec_cmp, dec_pref, dec_restart, dec_dir;
    step_stat_t dec_status;
    step_stat_t stat_q;

    owsearch_decide u_decide (
        .id_i      (dec_id),
        .cmp_i     (dec_cmp),
        .pref_i    (dec_pref),
        .restart_o (dec_restart),
        .dir_o     (dec_dir),
        .status_o  (dec_status)
    );

    owsearch_seq u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .start_i       (start_i),
        .pref_i        (pref_dir_i),
        .slot_ack_i    (slot_ack_i),
        .slot_rbit_i   (slot_rbit_i),
        .dec_id_o      (dec_id),
        .dec_cmp_o     (dec_cmp),
        .dec_pref_o    (dec_pref),
        .dec_restart_i (dec_restart),
        .dec_dir_i     (dec_dir),
        .dec_status_i  (dec_status),
        .slot_req_o    (slot_req_o),
        .slot_wr_o     (slot_wr_o),
        .slot_wbit_o   (slot_wbit_o),
        .busy_o        (busy_o),
        .done_o        (done_o),
        .status_o      (stat_q)
    );

    assign status_o = stat_q;

endmodule

// File: rtl/owsearch_step_chk.sv
module owsearch_step_chk
    import owsearch_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              slot_ack_i,
    input  logic              slot_req_o,
    input  logic              slot_wr_o,
    input  logic              slot_wbit_o,
    input  logic              busy_o,
    input  logic              done_o,
    input  logic [STAT_W-1:0] status_o
);

    logic [1:0] rd_seen;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rd_seen <= 2'd0;
        end else if (!busy_o && start_i) begin
            rd_seen <= 2'd0;
        end else if (slot_req_o && !slot_wr_o && slot_ack_i && rd_seen != 2'd3) begin
            rd_seen <= rd_seen + 2'd1;
        end
    end

    // R2
    write_after_reads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_req_o && slot_wr_o) |-> (rd_seen == 2'd2));

    // R3
    restart_no_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && status_o[STAT_ID] && status_o[STAT_CMP]) |-> !status_o[STAT_DIR]);

    // R6
    wbit_matches_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_req_o && slot_wr_o && slot_ack_i) |=>
            (done_o && status_o[STAT_DIR] == $past(slot_wbit_o)));

    // R7
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R7
    status_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(status_o));

    // R9
    req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_req_o && !slot_ack_i) |=>
            (slot_req_o && $stable(slot_wr_o) && $stable(slot_wbit_o)));

    // R5
    forced_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && (status_o[STAT_ID] != status_o[STAT_CMP])) |->
            (status_o[STAT_DIR] == status_o[STAT_ID]));

endmodule

bind owsearch_step owsearch_step_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .slot_ack_i  (slot_ack_i),
    .slot_req_o  (slot_req_o),
    .slot_wr_o   (slot_wr_o),
    .slot_wbit_o (slot_wbit_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .status_o    (status_o)
);

// File: tb/owsearch_step_tb_top.sv
`timescale 1ns/1ps
module owsearch_step_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       pref = 1'b0;
    logic       ack = 1'b0;
    logic       rbit = 1'b0;
    logic       req, wr, wbit, busy, done;
    logic [2:0] status;

    always #2.5 clk = ~clk;

    owsearch_step dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .pref_dir_i  (pref),
        .slot_ack_i  (ack),
        .slot_rbit_i (rbit),
        .slot_req_o  (req),
        .slot_wr_o   (wr),
        .slot_wbit_o (wbit),
        .busy_o      (busy),
        .done_o      (done),
        .status_o    (status)
    );

    int   checks = 0;
    int   errors = 0;

    // slot engine model
    int   lat = 0;
    int   cnt = 0;
    logic rd_bits [2];
    int   n_rd = 0;
    int   n_wr = 0;
    logic wr_bit = 1'b0;
    int   order_bad = 0;
    int   req_drop = 0;
    logic waiting = 1'b0;

    always @(negedge clk) begin
        if (!rst_n) begin
            ack = 1'b0; cnt = 0; waiting = 1'b0;
        end else if (ack) begin
            ack = 1'b0;
        end else if (req) begin
            if (cnt >= lat) begin
                ack = 1'b1; cnt = 0; waiting = 1'b0;
                if (wr) begin
                    n_wr++; wr_bit = wbit;
                end else begin
                    if (n_wr > 0) order_bad++;
                    rbit = (n_rd < 2) ? rd_bits[n_rd] : 1'b1;
                    n_rd++;
                end
            end else begin
                cnt++; waiting = 1'b1;
            end
        end else if (waiting) begin
            req_drop++; waiting = 1'b0;
        end
    end

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // returns 1 when done was seen
    task automatic run_op(input logic p, input logic id, input logic cm, input int l,
                          input logic extra_start, output logic seen);
        @(negedge clk);
        rd_bits[0] = id; rd_bits[1] = cm;
        n_rd = 0; n_wr = 0; wr_bit = 1'b0; order_bad = 0; req_drop = 0;
        lat = l; cnt = 0;
        start = 1'b1; pref = p;
        @(negedge clk);
        start = 1'b0; pref = ~p;
        if (extra_start) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 1'b0;
        for (int k = 0; k < 100 && !seen; k++) begin
            if (done) seen = 1'b1;
            else @(negedge clk);
        end
    endtask

    // {pref, id, cmp, status[2:0], write_expected, write_bit}
    localparam logic [7:0] VEC [8] = '{
        8'b000_000_1_0,
        8'b100_100_1_1,
        8'b010_101_1_1,
        8'b110_101_1_1,
        8'b001_010_1_0,
        8'b101_010_1_0,
        8'b011_011_0_0,
        8'b111_011_0_0
    };

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic       seen;
        logic [2:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(status == 3'b000, "R1 status", int'(status), 0);
        check(!done && !busy && !req, "R1 done/busy/req", int'({done, busy, req}), 0);
        rst_n = 1'b1;

        foreach (VEC[i]) begin
            logic [7:0] v;
            v = VEC[i];
            run_op(v[7], v[6], v[5], i % 3, 1'b0, seen);
            check(seen, "R7 done seen", int'(seen), 1);
            check(status == v[4:2], (v[6] & v[5]) ? "R3 status" :
                  (v[6] ^ v[5]) ? "R5 status" : "R4 status", int'(status), int'(v[4:2]));
            check(n_rd == 2 && order_bad == 0, "R2 two reads first", n_rd, 2);
            check(n_wr == int'(v[1]), v[1] ? "R6 write count" : "R3 no write", n_wr, int'(v[1]));
            if (v[1]) check(wr_bit == v[0], "R6 write bit", int'(wr_bit), int'(v[0]));
            check(req_drop == 0, "R9 request held", req_drop, 0);
            held = status;
            @(negedge clk);
            check(!done, "R7 single pulse", int'(done), 0);
            repeat (4) @(negedge clk);
            check(status == held, "R7 status held", int'(status), int'(held));
        end

        // R7: preference toggled while idle, no start: status unchanged
        held = status;
        for (int k = 0; k < 5; k++) begin
            pref = ~pref; @(negedge clk);
        end
        check(status == held && !busy, "R7 idle pref no effect", int'(status), int'(held));

        // R8: second start while busy ignored (pref=0, both reads 0)
        run_op(1'b0, 1'b0, 1'b0, 2, 1'b1, seen);
        check(status == 3'b000, "R8 pref not relatched", int'(status), 0);
        check(n_rd == 2 && n_wr == 1, "R8 no extra slots", n_rd + n_wr, 3);
        seen = 1'b0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (done || busy) seen = 1'b1;
        end
        check(!seen && n_rd == 2, "R8 no second operation", int'(seen), 0);

        // R9 long latency with forced direction
        run_op(1'b0, 1'b1, 1'b0, 7, 1'b0, seen);
        check(req_drop == 0 && status == 3'b101, "R9 long wait", int'(status), 5);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule